// File: doc/BRIEF.md
# Cascadable Serial Configuration Loader

This block fills the per-queue setup registers of a multi-queue buffer from a single serial bit stream. On each rising edge of the serial clock it takes one bit from the serial data input, but only while the active-low serial enable input is asserted. Once it has taken the exact number of bits that one device needs, `19 + 72*NUM_Q`, it freezes its registers. It then drives its enable output low and from that point passes both the serial data and the enable straight through. Several devices wired output-to-input therefore load one after another from one stream. When the enable output of the last device falls, the whole chain is configured.

A strap sampled during the synchronous active-low master reset selects default configuration instead. In that mode the serial data is ignored. The block writes one queue record per enabled clock: the memory is split evenly across all `NUM_Q` queues, and both offsets are set to 8 or 128 according to a second strap. It then signals completion on the enable output in the same way, so defaulted devices can be chained too.

The stream carries a 19-bit global header, then one 72-bit record for each queue starting with queue 0. Every field is sent most significant bit first. A queue record holds three 24-bit fields in this order: depth, almost-empty offset, almost-full offset.

Top module: `cfg_serial_loader`

## Requirements
- R1: A bit on `sdi` is stored only on a rising `clk` edge at which `sen_n` is 0. Edges with `sen_n` at 1 change neither the stored bits nor the bit count.
- R2: In serial mode `sen_out_n` stays 1 until exactly `19 + 72*NUM_Q` enabled edges have occurred. It goes to 0 in the cycle after the edge that takes the last bit, provided `sen_n` is 0.
- R3: Before loading completes, `sen_out_n` is 1 and `sdo` is 0, whatever `sdi` and `sen_n` do.
- R4: After loading completes, `sdo` equals `sdi` and `sen_out_n` equals `sen_n` combinationally, so a chain of n devices needs n times the per-device bit count.
- R5: The first stream bit lands in bit 18 of `cfg_hdr`. The next 72 bits form queue 0, made of `q_depth[23:0]`, then `q_ae_ofs[23:0]`, then `q_af_ofs[23:0]`, each MSB first. Queue k uses bits `[24k+23:24k]` of each vector.
- R6: Enabled bits beyond the required count are ignored and leave all configuration outputs unchanged.
- R7: If `dflt_mode` is 1 during reset, `sdi` is ignored. `sen_out_n` falls after exactly `NUM_Q` enabled edges, with the same pass-through afterwards.
- R8: In default mode every queue gets almost-empty and almost-full offsets of 8 if `dflt_ofs_hi` was 0 during reset, or 128 if it was 1.
- R9: In default mode every queue depth is `MEM_WORDS/NUM_Q`, and `cfg_hdr` holds `NUM_Q`.
- R10: While `rst_n` is 0, all configuration outputs clear and the straps are sampled. Strap changes after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial / configuration clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| sdi | input | 1 | Serial configuration data in |
| sen_n | input | 1 | Active-low serial enable in |
| dflt_mode | input | 1 | Strap: 1 selects default configuration |
| dflt_ofs_hi | input | 1 | Strap: default offsets 128 (1) or 8 (0) |
| sdo | output | 1 | Serial data out to next device |
| sen_out_n | output | 1 | Active-low enable out; falls when loaded |
| cfg_hdr | output | 19 | Global header field |
| q_depth | output | 24*NUM_Q | Per-queue depth fields |
| q_ae_ofs | output | 24*NUM_Q | Per-queue almost-empty offsets |
| q_af_ofs | output | 24*NUM_Q | Per-queue almost-full offsets |

## Verification
The assertions assume that the straps are held steady while reset is low and that `rst_n` is low from time zero until at least one clock edge has passed. The checker counts enabled edges itself, and it relies on `sen_n` being a clean level sampled at the rising edge. The bench drives every input at the falling edge, holds the straps fixed during each reset pulse, and only changes them after release to show that they are ignored.

// File: rtl/cfg_loader_pkg.sv
// Package: shared layout constants for the serial configuration loader.
// Assumes a fixed record format: 19-bit header, 72-bit queue record
// made of three 24-bit fields (depth, almost-empty, almost-full).
package cfg_loader_pkg;
    localparam int HDR_W   = 19;
    localparam int FIELD_W = 24;
    localparam int QWORD_W = 3 * FIELD_W;

    // Total serial bits one device consumes for nq queues.
    function automatic int total_bits(input int nq);
        return HDR_W + QWORD_W * nq;
    endfunction
endpackage

// File: rtl/cfg_bit_counter.sv
// Counts enabled configuration steps up to a run-time limit and raises a
// sticky done flag on the step that reaches it.
// Assumes limit is stable outside reset and nonzero.
module cfg_bit_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic             last,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    // Current step is the final one needed.
    assign last = step && (cnt == limit - 1'b1);

    // Step counter and sticky completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
            if (last) done <= 1'b1;
        end
    end
endmodule

// File: rtl/cfg_shift_store.sv
// Holds the configuration image. In serial mode shifts one bit in per
// step (first bit ends at the MSB); in default mode shifts one whole
// default queue record per step and writes the header on the last step.
// Samples both straps while reset is low.
module cfg_shift_store
    import cfg_loader_pkg::*;
#(
    parameter int NUM_Q     = 16,
    parameter int MEM_WORDS = 65536,
    localparam int TOTAL    = total_bits(NUM_Q)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dflt_mode,
    input  logic             dflt_ofs_hi,
    input  logic             sdi,
    input  logic             step,
    input  logic             last,
    output logic             mode_q,
    output logic             ofs_q,
    output logic [TOTAL-1:0] image
);
    localparam logic [FIELD_W-1:0] DEF_DEPTH = FIELD_W'(MEM_WORDS / NUM_Q);
    localparam logic [FIELD_W-1:0] OFS_LO    = FIELD_W'(8);
    localparam logic [FIELD_W-1:0] OFS_HI    = FIELD_W'(128);

    logic [QWORD_W-1:0] def_rec;
    logic [TOTAL-1:0]   def_next;

    // Default queue record built from the sampled offset strap.
    always_comb begin
        def_rec = {DEF_DEPTH, ofs_q ? OFS_HI : OFS_LO, ofs_q ? OFS_HI : OFS_LO};
        def_next = {image[TOTAL-1-QWORD_W:0], def_rec};
        if (last) def_next[TOTAL-1 -: HDR_W] = HDR_W'(NUM_Q);
    end

    // Strap capture during reset and image update on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= dflt_mode;
            ofs_q  <= dflt_ofs_hi;
            image  <= '0;
        end else if (step) begin
            if (mode_q) image <= def_next;
            else        image <= {image[TOTAL-2:0], sdi};
        end
    end
endmodule

// File: rtl/cfg_chain_bypass.sv
// Serial output stage: holds the chain outputs idle until loading is done,
// then forwards data and enable to the next device with no register delay.
module cfg_chain_bypass (
    input  logic done,
    input  logic sdi,
    input  logic sen_n,
    output logic sdo,
    output logic sen_out_n
);
    // Idle before completion, transparent after.
    always_comb begin
        sdo       = done & sdi;
        sen_out_n = ~done | sen_n;
    end
endmodule

// File: rtl/cfg_serial_loader.sv
// Top: cascadable serial configuration loader. Ties the step counter,
// image store and chain bypass together and unpacks the image into
// per-queue field vectors. Assumes synchronous active-low master reset.
module cfg_serial_loader
    import cfg_loader_pkg::*;
#(
    parameter int NUM_Q     = 16,
    parameter int MEM_WORDS = 65536
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sdi,
    input  logic                     sen_n,
    input  logic                     dflt_mode,
    input  logic                     dflt_ofs_hi,
    output logic                     sdo,
    output logic                     sen_out_n,
    output logic [HDR_W-1:0]         cfg_hdr,
    output logic [NUM_Q*FIELD_W-1:0] q_depth,
    output logic [NUM_Q*FIELD_W-1:0] q_ae_ofs,
    output logic [NUM_Q*FIELD_W-1:0] q_af_ofs
);
    localparam int TOTAL = total_bits(NUM_Q);
    localparam int CNT_W = $clog2(TOTAL + 1);

    logic             done;
    logic             last;
    logic             step;
    logic             mode_q;
    logic             ofs_q;
    logic [CNT_W-1:0] limit;
    logic [TOTAL-1:0] image;

    // A step happens on each enabled edge until the image is complete.
    assign step  = ~sen_n & ~done;
    assign limit = mode_q ? CNT_W'(NUM_Q) : CNT_W'(TOTAL);

    cfg_bit_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .limit (limit),
        .last  (last),
        .done  (done)
    );

    cfg_shift_store #(.NUM_Q(NUM_Q), .MEM_WORDS(MEM_WORDS)) i_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .dflt_mode   (dflt_mode),
        .dflt_ofs_hi (dflt_ofs_hi),
        .sdi         (sdi),
        .step        (step),
        .last        (last),
        .mode_q      (mode_q),
        .ofs_q       (ofs_q),
        .image       (image)
    );

    cfg_chain_bypass i_byp (
        .done      (done),
        .sdi       (sdi),
        .sen_n     (sen_n),
        .sdo       (sdo),
        .sen_out_n (sen_out_n)
    );

    assign cfg_hdr = image[TOTAL-1 -: HDR_W];

    // Unpack each queue record into its three field vectors.
    for (genvar k = 0; k < NUM_Q; k++) begin : g_q
        localparam int TOP = TOTAL - 1 - HDR_W - k * QWORD_W;
        assign q_depth [k*FIELD_W +: FIELD_W] = image[TOP -: FIELD_W];
        assign q_ae_ofs[k*FIELD_W +: FIELD_W] = image[TOP - FIELD_W -: FIELD_W];
        assign q_af_ofs[k*FIELD_W +: FIELD_W] = image[TOP - 2*FIELD_W -: FIELD_W];
    end
endmodule

// File: rtl/cfg_loader_checker.sv
// Checker for cfg_serial_loader: keeps its own count of enabled edges and
// its own copy of the straps, and relates them to the chain outputs.
module cfg_loader_checker
    import cfg_loader_pkg::*;
#(
    parameter int NUM_Q = 16,
    localparam int TOTAL = total_bits(NUM_Q),
    localparam int CW    = $clog2(TOTAL + 1)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sdi,
    input logic                     sen_n,
    input logic                     dflt_mode,
    input logic                     dflt_ofs_hi,
    input logic                     sdo,
    input logic                     sen_out_n,
    input logic                     done,
    input logic [NUM_Q*FIELD_W-1:0] q_ae_ofs,
    input logic [NUM_Q*FIELD_W-1:0] q_depth
);
    logic [CW-1:0] seen;
    logic          ck_mode;
    logic          ck_ofs;
    logic [CW-1:0] need;

    assign need = ck_mode ? CW'(NUM_Q) : CW'(TOTAL);

    // Independent enabled-edge count and strap copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen    <= '0;
            ck_mode <= dflt_mode;
            ck_ofs  <= dflt_ofs_hi;
        end else if (!sen_n && seen < need) begin
            seen <= seen + 1'b1;
        end
    end

    a_r3_idle_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        (seen < need) |-> (sen_out_n && !sdo));

    a_r2_done_at_count: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == need) |-> done);

    a_r2_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    a_r4_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == need) |-> (sdo == sdi && sen_out_n == sen_n));

    a_r6_frozen_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(q_depth) && $stable(q_ae_ofs)));

    a_r8_default_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_mode && seen == need) |->
            (q_ae_ofs[FIELD_W-1:0] == (ck_ofs ? FIELD_W'(128) : FIELD_W'(8))));
endmodule

bind cfg_serial_loader cfg_loader_checker #(.NUM_Q(NUM_Q)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sdi         (sdi),
    .sen_n       (sen_n),
    .dflt_mode   (dflt_mode),
    .dflt_ofs_hi (dflt_ofs_hi),
    .sdo         (sdo),
    .sen_out_n   (sen_out_n),
    .done        (done),
    .q_ae_ofs    (q_ae_ofs),
    .q_depth     (q_depth)
);

// File: tb/test_cfg_serial_loader.sv
// Directed bench for cfg_serial_loader with two queues.
module test_cfg_serial_loader;
    localparam int CLK_P = 10;
    localparam int NQ    = 2;
    localparam int MEMW  = 65536;
    localparam int TOT   = 19 + 72 * NQ;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sdi = 1'b0;
    logic sen_n = 1'b1;
    logic dflt_mode = 1'b0;
    logic dflt_ofs_hi = 1'b0;
    logic sdo, sen_out_n;
    logic [18:0]      cfg_hdr;
    logic [NQ*24-1:0] q_depth, q_ae_ofs, q_af_ofs;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    cfg_serial_loader #(.NUM_Q(NQ), .MEM_WORDS(MEMW)) i_cfg_serial_loader (
        .clk(clk), .rst_n(rst_n), .sdi(sdi), .sen_n(sen_n),
        .dflt_mode(dflt_mode), .dflt_ofs_hi(dflt_ofs_hi),
        .sdo(sdo), .sen_out_n(sen_out_n), .cfg_hdr(cfg_hdr),
        .q_depth(q_depth), .q_ae_ofs(q_ae_ofs), .q_af_ofs(q_af_ofs)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic do_reset(input logic mode, input logic ofs);
        @(negedge clk);
        rst_n = 1'b0; sen_n = 1'b1; sdi = 1'b0;
        dflt_mode = mode; dflt_ofs_hi = ofs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_bit(input logic b, input logic en);
        @(negedge clk);
        sdi = b; sen_n = !en;
        @(posedge clk);
        #1;
    endtask

    task automatic check_serial_fields(input string req);
        check(req, cfg_hdr, 19'h5A5C3);
        check(req, q_depth,  {24'h008000, 24'h001234});
        check(req, q_ae_ofs, {24'h000011, 24'h000040});
        check(req, q_af_ofs, {24'h000022, 24'h000100});
    endtask

    // R1 R2 R3 R5: serial load with disabled gaps.
    task automatic t_serial_load();
        logic [TOT-1:0] s;
        s = {19'h5A5C3, 24'h001234, 24'h000040, 24'h000100,
                        24'h008000, 24'h000011, 24'h000022};
        do_reset(1'b0, 1'b0);
        for (int i = TOT - 1; i >= 1; i--) begin
            send_bit(s[i], 1'b1);
            if (i % 40 == 0) send_bit(~s[i-1], 1'b0);
        end
        sdi = 1'b1; sen_n = 1'b0; #1;
        check("R2 not done one bit early", sen_out_n, 1'b1);
        check("R3 sdo held low", sdo, 1'b0);
        send_bit(s[0], 1'b1);
        sdi = 1'b0; #1;
        check("R2 done after full count", sen_out_n, 1'b0);
        check_serial_fields("R5 R1 field layout");
    endtask

    // R4: pass-through after completion.
    task automatic t_pass_through();
        @(negedge clk);
        sen_n = 1'b1; sdi = 1'b1; #1;
        check("R4 sen follows high", sen_out_n, 1'b1);
        check("R4 sdo follows one", sdo, 1'b1);
        sen_n = 1'b0; sdi = 1'b0; #1;
        check("R4 sen follows low", sen_out_n, 1'b0);
        check("R4 sdo follows zero", sdo, 1'b0);
    endtask

    // R6: bits beyond the count leave the image unchanged.
    task automatic t_extra_bits();
        for (int i = 0; i < 25; i++) send_bit(i[0], 1'b1);
        check_serial_fields("R6 extra bits ignored");
    endtask

    // R10: reset clears everything.
    task automatic t_reset_clear();
        do_reset(1'b0, 1'b0);
        @(negedge clk);
        sen_n = 1'b0; sdi = 1'b1; #1;
        check("R10 header cleared", cfg_hdr, 19'h0);
        check("R10 depth cleared", q_depth, '0);
        check("R3 R10 enable out idle", sen_out_n, 1'b1);
        check("R3 R10 sdo idle", sdo, 1'b0);
    endtask

    // R7 R8 R9 R10: default configuration.
    task automatic t_default(input logic ofs);
        logic [23:0] o;
        o = ofs ? 24'd128 : 24'd8;
        do_reset(1'b1, ofs);
        @(negedge clk);
        dflt_mode = 1'b0; dflt_ofs_hi = ~ofs;
        for (int i = 0; i < NQ - 1; i++) begin
            send_bit(1'b1, 1'b1);
            send_bit(1'b0, 1'b0);
        end
        sen_n = 1'b0; #1;
        check("R7 not done one step early", sen_out_n, 1'b1);
        send_bit(1'b0, 1'b1);
        check("R7 done after NUM_Q steps", sen_out_n, 1'b0);
        check("R8 R10 ae offsets", q_ae_ofs, {o, o});
        check("R8 R10 af offsets", q_af_ofs, {o, o});
        check("R9 depths", q_depth, {24'd32768, 24'd32768});
        check("R9 header queue count", cfg_hdr, 19'd2);
        send_bit(1'b1, 1'b1);
        check("R7 R4 sdo passes after default", sdo, 1'b1);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (2) @(negedge clk);
        #1;
        check("R10 reset enable out", sen_out_n, 1'b1);
        check("R10 reset sdo", sdo, 1'b0);
        t_serial_load();
        t_pass_through();
        t_extra_bits();
        t_reset_clear();
        t_default(1'b0);
        t_default(1'b1);
        summary();
    end
endmodule